// File: doc/BRIEF.md
# GPIO Interrupt Routing Mux

This block steers the interrupt requests of three GPIO banks onto a platform interrupt controller that has fewer inputs than there are sources. Bank 0 has 14 lines, bank 1 has 24 lines and bank 2 has 32 lines, which gives 70 sources. They reach 41 outputs: 38 dedicated outputs that each carry one source, and 3 shared outputs, one per bank. Each shared output is the OR of the lines of its bank that currently have no dedicated output.

A single 32-bit routing register sets the routing. Each register bit owns one pair of lines taken from two different banks. One member of the pair drives the dedicated output for that pair. The other member is folded into the shared output of its own bank. Bank 1 lines 18 to 23 are never paired and always keep their own dedicated outputs. Software writes the register through a plain write strobe and data bus, and can read the value back at any time. The path from the GPIO request lines to the outputs is purely combinational. Only the routing choice is held in a flop.

Top module: `gpio_irq_router`

## Requirements
- R1: Reset (active-low, asynchronous) clears the routing register, so `cfg_rdata` reads 0 while reset is held and just after it ends.
- R2: When `cfg_we` is high at a rising clock edge, `cfg_wdata` is stored and appears on `cfg_rdata` after that edge. Without `cfg_we`, the stored value holds.
- R3: For n in 0..13, register bit n pairs bank 0 line n with bank 2 line n. `dedicated_irq[n]` carries the bank 2 line when the bit is 1 and the bank 0 line when the bit is 0.
- R4: For k in 14..31, register bit k pairs bank 1 line k-14 with bank 2 line k. `dedicated_irq[k]` carries the bank 2 line when the bit is 1 and the bank 1 line when the bit is 0.
- R5: `dedicated_irq[37:32]` always equal bank 1 lines 23..18 in the same order, whatever the register holds.
- R6: `shared_irq[0]` is the OR of every bank 0 line n whose register bit n is 1.
- R7: `shared_irq[1]` is the OR of every bank 1 line m (m in 0..17) whose register bit m+14 is 1. Bank 1 lines 18..23 never reach it.
- R8: `shared_irq[2]` is the OR of every bank 2 line n whose register bit n is 0.
- R9: A change on any GPIO request line reaches the outputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the routing register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the routing register |
| cfg_wdata | input | 32 | Value written into the routing register |
| cfg_rdata | output | 32 | Current routing register value |
| bank0_irq | input | 14 | Interrupt requests from bank 0 |
| bank1_irq | input | 24 | Interrupt requests from bank 1 |
| bank2_irq | input | 32 | Interrupt requests from bank 2 |
| dedicated_irq | output | 38 | One-source outputs: 0..31 paired, 32..37 fixed |
| shared_irq | output | 3 | Per-bank OR of lines without a dedicated output |

## Verification
The routing register can be rewritten in the same cycle in which the request lines change. When that happens, an output must switch from one source to the other exactly at the write edge, while the rest of the path follows the inputs combinationally. The bench provokes this with a stretch of cycles in which every cycle carries both a fresh register write and a fresh input pattern. A behavioural model places each of the 70 sources at its destination using the register value the model has latched, and every output plus the read-back value is compared against it on each falling edge. A separate check changes one input between clock edges and samples the output before the next edge.

// File: rtl/gpio_irq_router_pkg.sv
package gpio_irq_router_pkg;
    localparam int unsigned BANK0_LINES  = 14;
    localparam int unsigned BANK1_LINES  = 24;
    localparam int unsigned BANK2_LINES  = 32;
    localparam int unsigned BANK1_FIXED  = 6;

    localparam int unsigned BANK1_PAIRED    = BANK1_LINES - BANK1_FIXED;
    localparam int unsigned PAIR_COUNT      = BANK0_LINES + BANK1_PAIRED;
    localparam int unsigned DEDICATED_COUNT = PAIR_COUNT + BANK1_FIXED;
    localparam int unsigned SHARED_COUNT    = 3;

    typedef logic [PAIR_COUNT-1:0] route_cfg_t;

    typedef struct packed {
        route_cfg_t route;
    } cfg_state_t;
endpackage

// File: rtl/router_cfg_reg.sv
module router_cfg_reg
    import gpio_irq_router_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  route_cfg_t wr_data,
    output route_cfg_t route
);
    cfg_state_t state_d;
    cfg_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.route = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign route = state_q.route;
endmodule

// File: rtl/router_pair_steer.sv
module router_pair_steer #(
    parameter int unsigned PAIRS = 32
) (
    input  logic [PAIRS-1:0] low_src,
    input  logic [PAIRS-1:0] high_src,
    input  logic [PAIRS-1:0] pick_high,
    output logic [PAIRS-1:0] ded_out,
    output logic [PAIRS-1:0] low_spill,
    output logic [PAIRS-1:0] high_spill
);
    // Each pair: the picked member takes the dedicated output,
    // the other member spills onto its bank's shared line.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign ded_out[p]    = pick_high[p] ? high_src[p] : low_src[p];
        assign low_spill[p]  = pick_high[p] & low_src[p];
        assign high_spill[p] = ~pick_high[p] & high_src[p];
    end
endmodule

// File: rtl/router_shared_or.sv
module router_shared_or #(
    parameter int unsigned WIDTH = 14
) (
    input  logic [WIDTH-1:0] spill,
    output logic             any
);
    assign any = |spill;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gpio_irq_router_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [13:0] bank0_irq,
    input  logic [23:0] bank1_irq,
    input  logic [31:0] bank2_irq,
    output logic [37:0] dedicated_irq,
    output logic [2:0]  shared_irq
);
    route_cfg_t              route_q;
    logic [PAIR_COUNT-1:0]   low_src;
    logic [PAIR_COUNT-1:0]   ded_paired;
    logic [PAIR_COUNT-1:0]   low_spill;
    logic [PAIR_COUNT-1:0]   high_spill;

    router_cfg_reg i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .route   (route_q)
    );

    // Low member of each pair: bank 0 first, then paired bank 1 lines.
    assign low_src = {bank1_irq[BANK1_PAIRED-1:0], bank0_irq};

    router_pair_steer #(.PAIRS(PAIR_COUNT)) i_steer (
        .low_src    (low_src),
        .high_src   (bank2_irq),
        .pick_high  (route_q),
        .ded_out    (ded_paired),
        .low_spill  (low_spill),
        .high_spill (high_spill)
    );

    router_shared_or #(.WIDTH(BANK0_LINES)) i_or0 (
        .spill (low_spill[BANK0_LINES-1:0]),
        .any   (shared_irq[0])
    );

    router_shared_or #(.WIDTH(BANK1_PAIRED)) i_or1 (
        .spill (low_spill[PAIR_COUNT-1:BANK0_LINES]),
        .any   (shared_irq[1])
    );

    router_shared_or #(.WIDTH(BANK2_LINES)) i_or2 (
        .spill (high_spill),
        .any   (shared_irq[2])
    );

    assign dedicated_irq = {bank1_irq[BANK1_LINES-1:BANK1_PAIRED], ded_paired};
    assign cfg_rdata     = route_q;
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic [13:0] bank0_irq,
    input logic [23:0] bank1_irq,
    input logic [31:0] bank2_irq,
    input logic [37:0] dedicated_irq,
    input logic [2:0]  shared_irq
);
    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == $past(cfg_wdata));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

    for (genvar k = 0; k < 32; k++) begin : g_pair_chk
        if (k < 14) begin : g_b0
            assert_pair_bank0_R3: assert property (@(posedge clk) disable iff (!rst_n)
                dedicated_irq[k] == (cfg_rdata[k] ? bank2_irq[k] : bank0_irq[k]));
        end else begin : g_b1
            assert_pair_bank1_R4: assert property (@(posedge clk) disable iff (!rst_n)
                dedicated_irq[k] == (cfg_rdata[k] ? bank2_irq[k] : bank1_irq[k-14]));
        end
    end

    assert_fixed_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dedicated_irq[37:32] == bank1_irq[23:18]);

    assert_shared_bank0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shared_irq[0] == |(bank0_irq & cfg_rdata[13:0]));

    assert_shared_bank1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shared_irq[1] == |(bank1_irq[17:0] & cfg_rdata[31:14]));

    assert_shared_bank2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shared_irq[2] == |(bank2_irq & ~cfg_rdata));
endmodule

bind gpio_irq_router gpio_irq_router_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .bank0_irq     (bank0_irq),
    .bank1_irq     (bank1_irq),
    .bank2_irq     (bank2_irq),
    .dedicated_irq (dedicated_irq),
    .shared_irq    (shared_irq)
);

// File: tb/test_gpio_irq_router.sv
`timescale 1ns/1ps
module test_gpio_irq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [13:0] bank0_irq = '0;
    logic [23:0] bank1_irq = '0;
    logic [31:0] bank2_irq = '0;
    logic [37:0] dedicated_irq;
    logic [2:0]  shared_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit compare_on = 1'b0;
    logic [31:0] m_cfg = '0;

    always #2.5 clk = ~clk;

    gpio_irq_router i_gpio_irq_router (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .bank0_irq     (bank0_irq),
        .bank1_irq     (bank1_irq),
        .bank2_irq     (bank2_irq),
        .dedicated_irq (dedicated_irq),
        .shared_irq    (shared_irq)
    );

    // Reference register state.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_cfg <= '0;
        else if (cfg_we) m_cfg <= cfg_wdata;
    end

    // Place every source at its destination; returns {shared, dedicated}.
    function automatic logic [40:0] model_route(input logic [31:0] c, input logic [13:0] a,
                                                input logic [23:0] b, input logic [31:0] z);
        logic [37:0] ded = '0;
        logic [2:0]  sh  = '0;
        for (int n = 0; n < 14; n++) begin
            if (c[n]) sh[0] = sh[0] | a[n];
            else      ded[n] = a[n];
        end
        for (int m = 0; m < 24; m++) begin
            if (m >= 18)       ded[32 + m - 18] = b[m];
            else if (c[m+14])  sh[1] = sh[1] | b[m];
            else               ded[m+14] = b[m];
        end
        for (int n = 0; n < 32; n++) begin
            if (c[n]) ded[n] = z[n];
            else      sh[2] = sh[2] | z[n];
        end
        return {sh, ded};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [40:0] e;
        string rq;
        e = model_route(m_cfg, bank0_irq, bank1_irq, bank2_irq);
        rq = "R3";
        for (int i = 37; i >= 0; i--)
            if (dedicated_irq[i] !== e[i]) rq = (i < 14) ? "R3" : (i < 32) ? "R4" : "R5";
        check(dedicated_irq === e[37:0], rq, {tag, " dedicated"},
              64'(dedicated_irq), 64'(e[37:0]));
        check(shared_irq[0] === e[38], "R6", {tag, " shared0"}, 64'(shared_irq[0]), 64'(e[38]));
        check(shared_irq[1] === e[39], "R7", {tag, " shared1"}, 64'(shared_irq[1]), 64'(e[39]));
        check(shared_irq[2] === e[40], "R8", {tag, " shared2"}, 64'(shared_irq[2]), 64'(e[40]));
        check(cfg_rdata === m_cfg, "R2", {tag, " readback"}, 64'(cfg_rdata), 64'(m_cfg));
    endtask

    always @(negedge clk) begin
        if (compare_on && rst_n) compare_all("cycle");
    end

    task automatic write_cfg(input logic [31:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic set_src(input logic [69:0] v);
        {bank2_irq, bank1_irq, bank0_irq} = v;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] cfgs [3];
        cfgs[0] = 32'h0000_0000;
        cfgs[1] = 32'hFFFF_FFFF;
        cfgs[2] = 32'hAAAA_5555;

        // R1: reset state
        set_src({70{1'b1}});
        repeat (3) @(posedge clk);
        #1;
        check(cfg_rdata === 32'h0, "R1", "rdata in reset", 64'(cfg_rdata), 64'h0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(cfg_rdata === 32'h0, "R1", "rdata after reset", 64'(cfg_rdata), 64'h0);
        check(shared_irq === 3'b100, "R6", "shared lines with zero routing",
              64'(shared_irq), 64'h4);
        compare_on = 1'b1;

        // R3..R8: walking single source under several routings
        for (int c = 0; c < 3; c++) begin
            set_src('0);
            write_cfg(cfgs[c]);
            for (int i = 0; i < 70; i++) begin
                set_src(70'd1 << i);
                @(posedge clk); #1;
            end
            set_src({70{1'b1}});
            @(posedge clk); #1;
            for (int r = 0; r < 20; r++) begin
                set_src({$urandom, $urandom, $urandom});
                @(posedge clk); #1;
            end
        end

        // R2/R3/R4: register write and input change in the same cycle
        for (int r = 0; r < 40; r++) begin
            cfg_we = 1'b1;
            cfg_wdata = $urandom;
            set_src({$urandom, $urandom, $urandom});
            @(posedge clk); #1;
        end
        cfg_we = 1'b0;

        // R9: combinational path between edges
        write_cfg(32'h0000_0020);
        set_src('0);
        @(negedge clk); #0.5;
        bank2_irq[5] = 1'b1;
        #0.5;
        check(dedicated_irq[5] === 1'b1, "R9", "bank2 line 5 between edges",
              64'(dedicated_irq[5]), 64'h1);
        bank0_irq[5] = 1'b1;
        #0.5;
        check(shared_irq[0] === 1'b1, "R9", "shared0 between edges",
              64'(shared_irq[0]), 64'h1);
        @(posedge clk); #1;

        // R5/R7: fixed bank 1 lines ignore the register
        write_cfg(32'hFFFF_FFFF);
        set_src({32'h0, 24'hFC_0000, 14'h0});
        #0.5;
        check(dedicated_irq[37:32] === 6'h3F, "R5", "fixed lines",
              64'(dedicated_irq[37:32]), 64'h3F);
        check(shared_irq[1] === 1'b0, "R7", "fixed lines kept off shared1",
              64'(shared_irq[1]), 64'h0);
        @(posedge clk); #1;

        // R1: reset mid-run clears the register
        rst_n = 1'b0;
        #1;
        check(cfg_rdata === 32'h0, "R1", "rdata after mid-run reset", 64'(cfg_rdata), 64'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(cfg_rdata === 32'h0, "R1", "rdata after reset release", 64'(cfg_rdata), 64'h0);
        compare_on = 1'b0;
        finish_run();
    end
endmodule